// File: doc/BRIEF.md
# Network Board Control and Parity-Error Capture

This block is the host-facing control and status logic of a network interface board. A 16-bit host port reaches three registers chosen by a 2-bit select. The control/status register holds the enables that drive the board. These are a reset for the network controller, an on-air switch that takes the link out of loopback, a channel-attention bit, two interrupt enables, a P2 bus enable, a RAM-size select and a 4-bit RAM window base. The same register also shows two flags that only hardware can set.

Channel attention is a plain register bit. To signal a new command, the host writes the bit high and then writes it low, and the attention output follows the bit. When the board RAM reports a parity error, the block freezes the failing 20-bit address, which byte half failed, and the source of the access. It holds that capture until the host writes an acknowledge bit. A single interrupt request combines the controller interrupt and the parity error, each gated by its own enable.

Top module: `nic_board_ctl`

## Requirements
- R1: A status write (select 0) stores bits 15,14,13,12,11,5,4 and 3:0. A status read returns those bits, with the parity flag at bit 9 and the interrupt flag at bit 8. Bits 10, 7 and 6 read 0. Select 3 reads 0.
- R2: `ctl_attn` follows status bit 13. `on_air` follows bit 14, `p2_en` follows bit 5, `ram_256k` follows bit 4 and `win_base` follows bits 3:0. Each output changes on the clock edge that performs the write.
- R3: While status bit 15 is 1, `ctl_reset` is high. While it is 1, the interrupt flag, the parity flag and all capture fields clear on every edge. `ctl_reset` is also high while `rst_n` is low.
- R4: The interrupt flag (bit 8) equals `ctl_irq_in` as sampled on the previous edge. Host writes to bits 9 and 8 have no effect on either flag.
- R5: A `par_err` pulse with no capture pending sets the parity flag on the next edge. On that edge it also captures `par_addr`, `par_hi` and `par_src`. Select 1 reads the source at bit 7, the byte half at bit 6 and address bits 19:16 at bits 3:0. Select 2 reads address bits 15:0.
- R6: While a capture is pending, further `par_err` pulses leave the flag and every capture field unchanged.
- R7: A write to select 1 with bit 8 set clears the parity flag on that edge, and bit 8 reads 0. If `par_err` arrives in the same cycle, the new error is captured and the flag stays 1. The capture fields keep their values after an acknowledge.
- R8: `irq` = (interrupt flag AND bit 12) OR (parity flag AND bit 11).
- R9: While `rst_n` is low, every register, flag and capture is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_sel | input | 2 | Register select: 0 status, 1 parity control, 2 failing address low, 3 none |
| host_we | input | 1 | Write strobe for the selected register |
| host_wdata | input | 16 | Write data |
| host_rdata | output | 16 | Read data of the selected register (combinational) |
| ctl_irq_in | input | 1 | Interrupt level from the network controller |
| par_err | input | 1 | RAM parity error pulse |
| par_addr | input | 20 | Address of the failing access |
| par_hi | input | 1 | 1 when the failing byte is the upper half |
| par_src | input | 1 | Source of the failing access |
| ctl_reset | output | 1 | Reset to the network controller |
| ctl_attn | output | 1 | Channel attention to the network controller |
| on_air | output | 1 | Link out of loopback |
| p2_en | output | 1 | P2 bus enable |
| ram_256k | output | 1 | RAM size select |
| win_base | output | 4 | RAM window base address bits |
| irq | output | 1 | Combined interrupt request |

## Verification
Two events can fall in the same cycle: an acknowledge write to the parity control register and a new parity error. The other colliding pair is a raised reset bit and an incoming error or interrupt. Directed cycles drive each pair together. The random phase also produces them freely, with a low bias toward the reset bit. The result is judged against a bench model, so an acknowledge that meets an error must leave the flag set with the new address captured, and the reset bit must win over any arriving event.

// File: rtl/nic_board_pkg.sv
package nic_board_pkg;
  localparam int REG_W = 16;
  localparam int PAR_ADDR_W = 20;
  localparam int HI_W = PAR_ADDR_W - REG_W;

  typedef enum logic [1:0] {
    SEL_STATUS = 2'd0,
    SEL_PARCTL = 2'd1,
    SEL_PARADR = 2'd2,
    SEL_NONE   = 2'd3
  } host_sel_e;

  localparam int B_RESET  = 15;
  localparam int B_ONAIR  = 14;
  localparam int B_ATTN   = 13;
  localparam int B_IEN    = 12;
  localparam int B_PIEN   = 11;
  localparam int B_PFLAG  = 9;
  localparam int B_IFLAG  = 8;
  localparam int B_P2     = 5;
  localparam int B_256K   = 4;
  localparam int B_ACK    = 8;
  localparam int B_SRC    = 7;
  localparam int B_HALF   = 6;

  localparam logic [REG_W-1:0] CTRL_MASK = 16'hF83F;
endpackage

// File: rtl/nic_ctrl_reg.sv
module nic_ctrl_reg
  import nic_board_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wdata,
  input  logic             ctl_irq_in,
  output logic [REG_W-1:0] ctrl_q,
  output logic             int_flag
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else if (wr_en) ctrl_q <= wdata & CTRL_MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) int_flag <= 1'b0;
    else if (ctrl_q[B_RESET]) int_flag <= 1'b0;
    else int_flag <= ctl_irq_in;
  end

  assert_flag_cleared_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q[B_RESET] |=> !int_flag);
  assert_write_no_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !ctl_irq_in) |=> !int_flag);
  assert_attn_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (ctrl_q[B_ATTN] == $past(wdata[B_ATTN])));
endmodule

// File: rtl/nic_par_capture.sv
module nic_par_capture
  import nic_board_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  clr,
  input  logic                  ack,
  input  logic                  err,
  input  logic [PAR_ADDR_W-1:0] err_addr,
  input  logic                  err_hi,
  input  logic                  err_src,
  output logic                  pending,
  output logic [PAR_ADDR_W-1:0] cap_addr,
  output logic                  cap_hi,
  output logic                  cap_src
);
  logic take;
  assign take = err && (!pending || ack);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending  <= 1'b0;
      cap_addr <= '0;
      cap_hi   <= 1'b0;
      cap_src  <= 1'b0;
    end else if (clr) begin
      pending  <= 1'b0;
      cap_addr <= '0;
      cap_hi   <= 1'b0;
      cap_src  <= 1'b0;
    end else begin
      if (take) begin
        pending  <= 1'b1;
        cap_addr <= err_addr;
        cap_hi   <= err_hi;
        cap_src  <= err_src;
      end else if (ack) begin
        pending <= 1'b0;
      end
    end
  end

  assert_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && !ack && !clr) |=> ($stable(cap_addr) && $stable(cap_hi) && $stable(cap_src) && pending));
  assert_error_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (err && !clr) |=> pending);
  assert_ack_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !err && !clr) |=> !pending);
  assert_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (!pending && cap_addr == '0));
endmodule

// File: rtl/nic_board_ctl.sv
module nic_board_ctl
  import nic_board_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [1:0]            host_sel,
  input  logic                  host_we,
  input  logic [REG_W-1:0]      host_wdata,
  output logic [REG_W-1:0]      host_rdata,
  input  logic                  ctl_irq_in,
  input  logic                  par_err,
  input  logic [PAR_ADDR_W-1:0] par_addr,
  input  logic                  par_hi,
  input  logic                  par_src,
  output logic                  ctl_reset,
  output logic                  ctl_attn,
  output logic                  on_air,
  output logic                  p2_en,
  output logic                  ram_256k,
  output logic [3:0]            win_base,
  output logic                  irq
);
  host_sel_e sel;
  logic [REG_W-1:0] ctrl_q;
  logic int_flag, par_flag, cap_hi, cap_src;
  logic [PAR_ADDR_W-1:0] cap_addr;
  logic wr_stat, wr_ack;

  assign sel     = host_sel_e'(host_sel);
  assign wr_stat = host_we && (sel == SEL_STATUS);
  assign wr_ack  = host_we && (sel == SEL_PARCTL) && host_wdata[B_ACK];

  nic_ctrl_reg u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_stat), .wdata(host_wdata),
    .ctl_irq_in(ctl_irq_in), .ctrl_q(ctrl_q), .int_flag(int_flag)
  );

  nic_par_capture u_par (
    .clk(clk), .rst_n(rst_n), .clr(ctrl_q[B_RESET]), .ack(wr_ack),
    .err(par_err), .err_addr(par_addr), .err_hi(par_hi), .err_src(par_src),
    .pending(par_flag), .cap_addr(cap_addr), .cap_hi(cap_hi), .cap_src(cap_src)
  );

  always_comb begin
    host_rdata = '0;
    case (sel)
      SEL_STATUS: begin
        host_rdata = ctrl_q;
        host_rdata[B_PFLAG] = par_flag;
        host_rdata[B_IFLAG] = int_flag;
      end
      SEL_PARCTL: begin
        host_rdata[B_SRC]  = cap_src;
        host_rdata[B_HALF] = cap_hi;
        host_rdata[HI_W-1:0] = cap_addr[PAR_ADDR_W-1:REG_W];
      end
      SEL_PARADR: host_rdata = cap_addr[REG_W-1:0];
      default: host_rdata = '0;
    endcase
  end

  assign ctl_reset = !rst_n || ctrl_q[B_RESET];
  assign ctl_attn  = ctrl_q[B_ATTN];
  assign on_air    = ctrl_q[B_ONAIR];
  assign p2_en     = ctrl_q[B_P2];
  assign ram_256k  = ctrl_q[B_256K];
  assign win_base  = ctrl_q[3:0];
  assign irq       = (int_flag && ctrl_q[B_IEN]) || (par_flag && ctrl_q[B_PIEN]);

  assert_irq_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_q[B_IEN] && !ctrl_q[B_PIEN]) |-> !irq);
  assert_parity_irq_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (par_flag && ctrl_q[B_PIEN]) |-> irq);
  assert_reset_out_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stat |=> (ctl_reset == $past(host_wdata[B_RESET])));
endmodule

// File: tb/nic_board_ctl_bench.sv
module nic_board_ctl_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] host_sel = 2'd0;
  logic host_we = 1'b0;
  logic [15:0] host_wdata = 16'h0;
  logic [15:0] host_rdata;
  logic ctl_irq_in = 1'b0, par_err = 1'b0, par_hi = 1'b0, par_src = 1'b0;
  logic [19:0] par_addr = 20'h0;
  logic ctl_reset, ctl_attn, on_air, p2_en, ram_256k, irq;
  logic [3:0] win_base;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  // bench model
  logic [15:0] m_ctrl;
  logic m_if, m_pf, m_hi, m_src;
  logic [19:0] m_addr;

  always #5 clk = ~clk;

  nic_board_ctl u_nic_board_ctl (
    .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_we(host_we),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .ctl_irq_in(ctl_irq_in),
    .par_err(par_err), .par_addr(par_addr), .par_hi(par_hi), .par_src(par_src),
    .ctl_reset(ctl_reset), .ctl_attn(ctl_attn), .on_air(on_air), .p2_en(p2_en),
    .ram_256k(ram_256k), .win_base(win_base), .irq(irq)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_rd(logic [1:0] s);
    case (s)
      2'd0: exp_rd = m_ctrl | {6'b0, m_pf, m_if, 8'b0};
      2'd1: exp_rd = {8'b0, m_src, m_hi, 2'b0, m_addr[19:16]};
      2'd2: exp_rd = m_addr[15:0];
      default: exp_rd = 16'h0;
    endcase
  endfunction

  function automatic logic exp_irq();
    exp_irq = (m_if && m_ctrl[12]) || (m_pf && m_ctrl[11]);
  endfunction

  task automatic cyc(logic we, logic [1:0] s, logic [15:0] wd, logic ci,
                     logic pe, logic [19:0] pa, logic ph, logic ps);
    logic [15:0] n_ctrl;
    logic n_if, n_pf, n_hi, n_src, ack;
    logic [19:0] n_addr;
    @(negedge clk);
    host_we = we; host_sel = s; host_wdata = wd; ctl_irq_in = ci;
    par_err = pe; par_addr = pa; par_hi = ph; par_src = ps;
    n_ctrl = (we && s == 2'd0) ? (wd & 16'hF83F) : m_ctrl;
    n_if = m_ctrl[15] ? 1'b0 : ci;
    ack = we && s == 2'd1 && wd[8];
    n_pf = m_pf; n_addr = m_addr; n_hi = m_hi; n_src = m_src;
    if (m_ctrl[15]) begin
      n_pf = 0; n_addr = 0; n_hi = 0; n_src = 0;
    end else if (pe && (!m_pf || ack)) begin
      n_pf = 1; n_addr = pa; n_hi = ph; n_src = ps;
    end else if (ack) n_pf = 0;
    @(posedge clk);
    #1;
    m_ctrl = n_ctrl; m_if = n_if; m_pf = n_pf; m_addr = n_addr; m_hi = n_hi; m_src = n_src;
  endtask

  task automatic check_all(string req);
    chk({req, " rdata"}, {16'b0, host_rdata}, {16'b0, exp_rd(host_sel)});
    chk({req, " irq R8"}, {31'b0, irq}, {31'b0, exp_irq()});
    chk({req, " reset R3"}, {31'b0, ctl_reset}, {31'b0, m_ctrl[15]});
    chk({req, " attn R2"}, {31'b0, ctl_attn}, {31'b0, m_ctrl[13]});
  endtask

  initial begin
    #(20000 * 10);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    m_ctrl = 0; m_if = 0; m_pf = 0; m_addr = 0; m_hi = 0; m_src = 0;
    // R9 reset state
    repeat (3) @(posedge clk);
    #1;
    for (int s = 0; s < 4; s++) begin
      host_sel = 2'(s);
      #1;
      chk("R9 read under reset", {16'b0, host_rdata}, 32'h0);
    end
    chk("R3 ctl_reset while rst_n low", {31'b0, ctl_reset}, 32'h1);
    chk("R9 irq under reset", {31'b0, irq}, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;

    // R1/R2 directed write
    cyc(1, 2'd0, 16'h7FFF, 0, 0, 0, 0, 0);
    host_sel = 2'd0; #1;
    chk("R1 status readback", {16'b0, host_rdata}, 32'h783F);
    chk("R2 attn", {31'b0, ctl_attn}, 32'h1);
    chk("R2 fields", {27'b0, on_air, p2_en, ram_256k, win_base[0], win_base == 4'hF}, 32'h1F);
    cyc(1, 2'd3, 16'hFFFF, 0, 0, 0, 0, 0);
    chk("R1 select 3 reads zero", {16'b0, host_rdata}, 32'h0);
    cyc(1, 2'd0, 16'h1300, 0, 0, 0, 0, 0);
    chk("R4 host cannot set flags", {16'b0, host_rdata}, 32'h1000);
    chk("R2 attn dropped", {31'b0, ctl_attn}, 32'h0);

    // R4/R8 controller interrupt
    cyc(0, 2'd0, 0, 1, 0, 0, 0, 0);
    chk("R4 interrupt flag", {16'b0, host_rdata}, 32'h1100);
    chk("R8 irq from controller", {31'b0, irq}, 32'h1);
    cyc(0, 2'd0, 0, 0, 0, 0, 0, 0);
    chk("R4 flag follows input", {16'b0, host_rdata}, 32'h1000);

    // R5 capture
    cyc(1, 2'd0, 16'h0800, 0, 1, 20'hA5C3E, 1, 0);
    cyc(0, 2'd1, 0, 0, 0, 0, 0, 0);
    chk("R5 parity ctrl read", {16'b0, host_rdata}, 32'h004A);
    chk("R8 irq from parity", {31'b0, irq}, 32'h1);
    cyc(0, 2'd2, 0, 0, 0, 0, 0, 0);
    chk("R5 addr low read", {16'b0, host_rdata}, 32'h5C3E);
    // R6 later error ignored
    cyc(0, 2'd2, 0, 0, 1, 20'h12345, 0, 1);
    chk("R6 capture frozen", {16'b0, host_rdata}, 32'h5C3E);
    // R7 ack together with new error
    cyc(1, 2'd1, 16'h0100, 0, 1, 20'h6789A, 0, 1);
    chk("R7 ack with new error captures", {16'b0, host_rdata}, 32'h0086);
    cyc(1, 2'd1, 16'h0100, 0, 0, 0, 0, 0);
    chk("R7 ack bit reads 0, capture kept", {16'b0, host_rdata}, 32'h0086);
    cyc(0, 2'd0, 0, 0, 0, 0, 0, 0);
    chk("R7 flag cleared", {16'b0, host_rdata}, 32'h0800);
    // R3 reset bit with incoming error and interrupt
    cyc(1, 2'd0, 16'h9800, 1, 0, 0, 0, 0);
    chk("R3 reset bit drives ctl_reset", {31'b0, ctl_reset}, 32'h1);
    cyc(0, 2'd2, 0, 1, 1, 20'hFFFFF, 1, 1);
    chk("R3 capture cleared under reset bit", {16'b0, host_rdata}, 32'h0);
    cyc(1, 2'd0, 16'h0000, 0, 0, 0, 0, 0);
    chk("R3 flags cleared", {16'b0, host_rdata}, 32'h0);

    // random phase
    for (int i = 0; i < 4000; i++) begin
      logic [15:0] wd;
      logic [1:0] s;
      wd = 16'($urandom());
      if (($urandom() % 8) != 0) wd[15] = 1'b0;
      s = 2'($urandom());
      cyc(($urandom() % 3) == 0, s, wd, 1'($urandom()), ($urandom() % 4) == 0,
          20'($urandom()), 1'($urandom()), 1'($urandom()));
      check_all(s == 2'd0 ? "R1 R4" : (s == 2'd3 ? "R1" : "R5 R6 R7"));
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule